// File: doc/BRIEF.md
# Programmable Wait State Controller

This block decides how many wait states, from 0 to 3, a bus cycle receives, and it tells the bus sequencer when the cycle may finish. When a cycle starts, the controller looks at the cycle's kind and its address. It then picks the wait count for that cycle from a set of configuration registers. Memory cycles issued by the processor use a memory map with three or five blocks. Processor I/O cycles use an I/O map that is either undivided or split into three blocks. DMA cycles and refresh cycles ignore the address and each use their own fixed setting.

A down-counter is loaded with the chosen count when the cycle starts. It is then combined with an already synchronized READY input, so an external device can stretch the cycle beyond the programmed count. The number of wait states actually inserted is the larger of the programmed count and the number of cycles READY is held low. The bus state machine that consumes the done indication lies outside this block.

Top module: `wait_state_ctrl`

## Requirements
- R1: After reset, every wait field holds 3, the memory map uses three blocks, the I/O space is one undivided block, and `cyc_done` is low.
- R2: A write with `cfg_we` high updates the register at `cfg_addr` on that clock edge. The register layout is as follows:
  - Register 0: bit0 enables the five-block memory map, and bit1 enables the three-block I/O map.
  - Register 1: bits [1:0] lower-sub, [3:2] lower, [5:4] middle and [7:6] upper memory waits.
  - Register 2: bits [1:0] upper-sub memory wait, [3:2] low, [5:4] middle and [7:6] high I/O waits.
  - Register 3: bits [1:0] DMA wait and [3:2] refresh wait.
  - Registers 4 to 7: memory boundaries B0 to B3.
  - Registers 8 and 9: I/O boundaries C0 and C1.
- R3: With the five-block map off, a processor memory cycle compares `cyc_addr[19:12]` against the boundaries. A value below B1 selects the lower block, a value below B2 selects the middle block, and anything else selects the upper block. The two sub-blocks are never selected in this mode.
- R4: With the five-block map on, a value of `cyc_addr[19:12]` below B0 selects the lower-sub block, and a value at or above B3 selects the upper-sub block. Any other value is decoded as in R3.
- R5: A processor I/O cycle (`cyc_is_io`=1) decodes only `cyc_addr[15:8]`. With the I/O split off, the whole I/O space uses the middle I/O wait. With the split on, a value below C0 selects the low block, a value below C1 selects the middle block, and anything else selects the high block.
- R6: `cyc_kind` 1 (DMA) always uses the DMA wait, and `cyc_kind` 2 (refresh) always uses the refresh wait, whatever the address and `cyc_is_io`. `cyc_kind` 0 is a processor cycle, and 3 is treated the same as 0.
- R7: With `rdy_sync` high and a programmed count of N, `cyc_done` first goes high in the clock period that begins N edges after the edge that samples `cyc_start`.
- R8: `cyc_done` is high only while `rdy_sync` is high. If READY is low when the count expires, the cycle waits until READY returns, so the waits inserted are the larger of N and the READY hold-off.
- R9: `cyc_done` lasts a single clock period unless a new cycle starts. A `cyc_start` during a cycle that is still active abandons that cycle and reloads the count for the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write data |
| cyc_start | input | 1 | One-clock pulse that starts a bus cycle |
| cyc_addr | input | 20 | Address of the starting cycle |
| cyc_is_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| cyc_kind | input | 2 | 0/3 processor, 1 DMA, 2 refresh |
| rdy_sync | input | 1 | Synchronized READY from the bus |
| cyc_done | output | 1 | The current cycle may end in this clock period |

## Verification
On every cycle, the assertions check several properties:
- the memory decode is one-hot;
- the sub-blocks stay unused in three-block mode;
- an undivided I/O map always lands on the middle block;
- the counter steps down by one each clock;
- a cycle waiting on READY stays open;
- `cyc_done` never lasts past one clock period;
- the registers hold steady without a write.

Whether each address falls into the right block at every boundary cannot be shown by any per-cycle property. Nor can the count measured at the ports, the reset defaults, or the DMA and refresh overrides. Only the bench's scenarios can show these.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  typedef enum logic [1:0] {
    KIND_CPU  = 2'd0,
    KIND_DMA  = 2'd1,
    KIND_RFSH = 2'd2,
    KIND_ALT  = 2'd3
  } wsc_kind_e;

  localparam int MEM_BLOCKS = 5;
  localparam int IO_BLOCKS  = 3;
  localparam int MEM_BNDS   = 4;
  localparam int IO_BNDS    = 2;
endpackage

// File: rtl/wsc_cfg_regs.sv
module wsc_cfg_regs
  import wsc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WAIT_W = 2,
  parameter int IDX_W  = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cfg_we,
  input  logic [IDX_W-1:0]                    cfg_addr,
  input  logic [DATA_W-1:0]                   cfg_wdata,
  output logic                                mem5_en,
  output logic                                io_split,
  output logic [MEM_BLOCKS-1:0][WAIT_W-1:0]   mem_wait,
  output logic [IO_BLOCKS-1:0][WAIT_W-1:0]    io_wait,
  output logic [WAIT_W-1:0]                   dma_wait,
  output logic [WAIT_W-1:0]                   rf_wait,
  output logic [MEM_BNDS-1:0][DATA_W-1:0]     mem_bnd,
  output logic [IO_BNDS-1:0][DATA_W-1:0]      io_bnd
);
  localparam logic [WAIT_W-1:0] WAIT_RST = '1;
  localparam logic [DATA_W-1:0] QTR      = DATA_W'(1) << (DATA_W - 2);
  localparam logic [DATA_W-1:0] SIXT     = DATA_W'(1) << (DATA_W - 4);
  localparam logic [DATA_W-1:0] MB0_RST  = SIXT;
  localparam logic [DATA_W-1:0] MB1_RST  = QTR;
  localparam logic [DATA_W-1:0] MB2_RST  = QTR * 3;
  localparam logic [DATA_W-1:0] MB3_RST  = SIXT * 15;

  // write decode, brought out for the assertions
  logic we_ctrl, we_mw, we_mixw, we_fix;
  assign we_ctrl = cfg_we && (cfg_addr == IDX_W'(0));
  assign we_mw   = cfg_we && (cfg_addr == IDX_W'(1));
  assign we_mixw = cfg_we && (cfg_addr == IDX_W'(2));
  assign we_fix  = cfg_we && (cfg_addr == IDX_W'(3));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem5_en  <= 1'b0;
      io_split <= 1'b0;
      dma_wait <= WAIT_RST;
      rf_wait  <= WAIT_RST;
    end else begin
      if (we_ctrl) begin
        mem5_en  <= cfg_wdata[0];
        io_split <= cfg_wdata[1];
      end
      if (we_fix) begin
        dma_wait <= cfg_wdata[0 +: WAIT_W];
        rf_wait  <= cfg_wdata[WAIT_W +: WAIT_W];
      end
    end
  end

  // four memory wait fields share register 1
  for (genvar i = 0; i < MEM_BLOCKS - 1; i++) begin : g_mw
    always_ff @(posedge clk) begin
      if (!rst_n)     mem_wait[i] <= WAIT_RST;
      else if (we_mw) mem_wait[i] <= cfg_wdata[i*WAIT_W +: WAIT_W];
    end
  end

  // upper-sub memory wait and the three I/O waits share register 2
  always_ff @(posedge clk) begin
    if (!rst_n)       mem_wait[MEM_BLOCKS-1] <= WAIT_RST;
    else if (we_mixw) mem_wait[MEM_BLOCKS-1] <= cfg_wdata[0 +: WAIT_W];
  end

  for (genvar j = 0; j < IO_BLOCKS; j++) begin : g_iw
    always_ff @(posedge clk) begin
      if (!rst_n)       io_wait[j] <= WAIT_RST;
      else if (we_mixw) io_wait[j] <= cfg_wdata[(j+1)*WAIT_W +: WAIT_W];
    end
  end

  for (genvar k = 0; k < MEM_BNDS; k++) begin : g_mb
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem_bnd[k] <= (k == 0) ? MB0_RST : (k == 1) ? MB1_RST : (k == 2) ? MB2_RST : MB3_RST;
      else if (cfg_we && cfg_addr == IDX_W'(4 + k))
        mem_bnd[k] <= cfg_wdata;
    end
  end

  for (genvar m = 0; m < IO_BNDS; m++) begin : g_ib
    always_ff @(posedge clk) begin
      if (!rst_n)
        io_bnd[m] <= (m == 0) ? MB1_RST : MB2_RST;
      else if (cfg_we && cfg_addr == IDX_W'(4 + MEM_BNDS + m))
        io_bnd[m] <= cfg_wdata;
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(mem_wait) && $stable(io_wait) && $stable(mem5_en) && $stable(io_split))); // R2
endmodule

// File: rtl/wsc_region_dec.sv
module wsc_region_dec
  import wsc_pkg::*;
#(
  parameter int CMP_W  = 8,
  parameter int WAIT_W = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [CMP_W-1:0]                   mem_hi,
  input  logic [CMP_W-1:0]                   io_hi,
  input  logic                               is_io,
  input  logic [1:0]                         kind,
  input  logic                               mem5_en,
  input  logic                               io_split,
  input  logic [MEM_BNDS-1:0][CMP_W-1:0]     mem_bnd,
  input  logic [IO_BNDS-1:0][CMP_W-1:0]      io_bnd,
  input  logic [MEM_BLOCKS-1:0][WAIT_W-1:0]  mem_wait,
  input  logic [IO_BLOCKS-1:0][WAIT_W-1:0]   io_wait,
  input  logic [WAIT_W-1:0]                  dma_wait,
  input  logic [WAIT_W-1:0]                  rf_wait,
  output logic [WAIT_W-1:0]                  load_wait
);
  function automatic logic [MEM_BLOCKS-1:0] mem_block(
    input logic [CMP_W-1:0] hi, input logic [MEM_BNDS-1:0][CMP_W-1:0] b, input logic five);
    logic [MEM_BLOCKS-1:0] r;
    r = '0;
    if (five && hi < b[0])       r[0] = 1'b1;
    else if (five && hi >= b[3]) r[4] = 1'b1;
    else if (hi < b[1])          r[1] = 1'b1;
    else if (hi < b[2])          r[2] = 1'b1;
    else                         r[3] = 1'b1;
    return r;
  endfunction

  function automatic logic [IO_BLOCKS-1:0] io_block(
    input logic [CMP_W-1:0] hi, input logic [IO_BNDS-1:0][CMP_W-1:0] b, input logic split);
    logic [IO_BLOCKS-1:0] r;
    r = '0;
    if (!split)        r[1] = 1'b1;
    else if (hi < b[0]) r[0] = 1'b1;
    else if (hi < b[1]) r[1] = 1'b1;
    else               r[2] = 1'b1;
    return r;
  endfunction

  logic [MEM_BLOCKS-1:0] mem_sel;
  logic [IO_BLOCKS-1:0]  io_sel;
  logic [WAIT_W-1:0]     mem_pick, io_pick;

  assign mem_sel = mem_block(mem_hi, mem_bnd, mem5_en);
  assign io_sel  = io_block(io_hi, io_bnd, io_split);

  always_comb begin
    mem_pick = '0;
    io_pick  = '0;
    for (int i = 0; i < MEM_BLOCKS; i++) if (mem_sel[i]) mem_pick |= mem_wait[i];
    for (int j = 0; j < IO_BLOCKS; j++)  if (io_sel[j])  io_pick  |= io_wait[j];
    case (wsc_kind_e'(kind))
      KIND_DMA:  load_wait = dma_wait;
      KIND_RFSH: load_wait = rf_wait;
      default:   load_wait = is_io ? io_pick : mem_pick;
    endcase
  end

  AST_MEM_ONE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mem_sel) == 1); // R3
  AST_NO_SUB_IN_THREE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem5_en |-> (!mem_sel[0] && !mem_sel[4])); // R3
  AST_IO_WHOLE_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    !io_split |-> (io_sel == 3'b010)); // R5
endmodule

// File: rtl/wsc_wait_cnt.sv
module wsc_wait_cnt #(
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_start,
  input  logic [WAIT_W-1:0] load_wait,
  input  logic              rdy_sync,
  output logic              cyc_done
);
  logic              active;
  logic [WAIT_W-1:0] cnt;
  logic              expired;

  assign expired  = active && (cnt == '0);
  assign cyc_done = expired && rdy_sync;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (cyc_start) begin
      active <= 1'b1;
      cnt    <= load_wait;
    end else if (cyc_done) begin
      active <= 1'b0;
    end else if (active && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !cyc_start && cnt != '0) |=> (active && cnt == $past(cnt) - 1'b1)); // R7
  AST_WAIT_FOR_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !rdy_sync && !cyc_start) |=> (active && cnt == '0)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_done && !cyc_start) |=> !cyc_done); // R9
  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> (active && cnt == $past(load_wait))); // R7
endmodule

// File: rtl/wait_state_ctrl.sv
module wait_state_ctrl
  import wsc_pkg::*;
#(
  parameter int MEM_AW = 20,
  parameter int IO_AW  = 16,
  parameter int DATA_W = 8,
  parameter int WAIT_W = 2,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              cyc_start,
  input  logic [MEM_AW-1:0] cyc_addr,
  input  logic              cyc_is_io,
  input  logic [1:0]        cyc_kind,
  input  logic              rdy_sync,
  output logic              cyc_done
);
  localparam int CMP_W = DATA_W;

  logic                              mem5_en, io_split;
  logic [MEM_BLOCKS-1:0][WAIT_W-1:0] mem_wait;
  logic [IO_BLOCKS-1:0][WAIT_W-1:0]  io_wait;
  logic [WAIT_W-1:0]                 dma_wait, rf_wait, load_wait;
  logic [MEM_BNDS-1:0][CMP_W-1:0]    mem_bnd;
  logic [IO_BNDS-1:0][CMP_W-1:0]     io_bnd;

  wsc_cfg_regs #(.DATA_W(DATA_W), .WAIT_W(WAIT_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .mem5_en(mem5_en), .io_split(io_split), .mem_wait(mem_wait), .io_wait(io_wait),
    .dma_wait(dma_wait), .rf_wait(rf_wait), .mem_bnd(mem_bnd), .io_bnd(io_bnd)
  );

  wsc_region_dec #(.CMP_W(CMP_W), .WAIT_W(WAIT_W)) u_dec (
    .clk(clk), .rst_n(rst_n),
    .mem_hi(cyc_addr[MEM_AW-1 -: CMP_W]), .io_hi(cyc_addr[IO_AW-1 -: CMP_W]),
    .is_io(cyc_is_io), .kind(cyc_kind), .mem5_en(mem5_en), .io_split(io_split),
    .mem_bnd(mem_bnd), .io_bnd(io_bnd), .mem_wait(mem_wait), .io_wait(io_wait),
    .dma_wait(dma_wait), .rf_wait(rf_wait), .load_wait(load_wait)
  );

  wsc_wait_cnt #(.WAIT_W(WAIT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .load_wait(load_wait),
    .rdy_sync(rdy_sync), .cyc_done(cyc_done)
  );
endmodule

// File: tb/test_wait_state_ctrl.sv
module test_wait_state_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        cyc_start = 1'b0;
  logic [19:0] cyc_addr = '0;
  logic        cyc_is_io = 1'b0;
  logic [1:0]  cyc_kind = '0;
  logic        rdy_sync = 1'b1;
  logic        cyc_done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  wait_state_ctrl i_wait_state_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cyc_start(cyc_start), .cyc_addr(cyc_addr), .cyc_is_io(cyc_is_io), .cyc_kind(cyc_kind),
    .rdy_sync(rdy_sync), .cyc_done(cyc_done)
  );

  // {ctrl, io, kind, addr, expected waits}
  // waits: msub0 mlow1 mmid2 mup3 musub2, io low0 mid1 high3, dma1 rf2
  // bounds: mem 10/40/80/F0, io 20/A0
  localparam logic [32:0] VEC [22] = '{
    {8'h03, 1'b0, 2'd0, 20'h0FFFF, 2'd0},  // R4 lower-sub
    {8'h03, 1'b0, 2'd0, 20'h10000, 2'd1},  // R4 B0 edge -> lower
    {8'h03, 1'b0, 2'd0, 20'h3FFFF, 2'd1},  // R3
    {8'h03, 1'b0, 2'd0, 20'h40000, 2'd2},  // R3
    {8'h03, 1'b0, 2'd0, 20'h7FFFF, 2'd2},  // R3
    {8'h03, 1'b0, 2'd0, 20'h80000, 2'd3},  // R3
    {8'h03, 1'b0, 2'd0, 20'hEFFFF, 2'd3},  // R4
    {8'h03, 1'b0, 2'd0, 20'hF0000, 2'd2},  // R4 upper-sub
    {8'h03, 1'b1, 2'd0, 20'h01FFF, 2'd0},  // R5 low
    {8'h03, 1'b1, 2'd0, 20'h02000, 2'd1},  // R5 mid
    {8'h03, 1'b1, 2'd0, 20'h09FFF, 2'd1},  // R5
    {8'h03, 1'b1, 2'd0, 20'h0A000, 2'd3},  // R5 high
    {8'h03, 1'b1, 2'd0, 20'hF1FFF, 2'd0},  // R5 upper bits ignored
    {8'h03, 1'b0, 2'd1, 20'h00000, 2'd1},  // R6 dma
    {8'h03, 1'b1, 2'd1, 20'h0A000, 2'd1},  // R6 dma io
    {8'h03, 1'b0, 2'd2, 20'hF0000, 2'd2},  // R6 refresh
    {8'h03, 1'b0, 2'd3, 20'h40000, 2'd2},  // R6 kind 3 as cpu
    {8'h00, 1'b0, 2'd0, 20'h0FFFF, 2'd1},  // R3 no sub
    {8'h00, 1'b0, 2'd0, 20'hF0000, 2'd3},  // R3 no sub
    {8'h00, 1'b1, 2'd0, 20'h01FFF, 2'd1},  // R5 undivided
    {8'h00, 1'b1, 2'd0, 20'h0A000, 2'd1},  // R5 undivided
    {8'h02, 1'b1, 2'd0, 20'h0A000, 2'd3}   // R2 io split only
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic launch(input logic io, input logic [1:0] k, input logic [19:0] a);
    @(negedge clk);
    cyc_start = 1'b1; cyc_is_io = io; cyc_kind = k; cyc_addr = a;
    @(posedge clk); #1;
    cyc_start = 1'b0;
  endtask

  task automatic measure(output int waits);
    int n = 0;
    while (!cyc_done && n < 8) begin
      @(posedge clk); #1;
      n++;
    end
    waits = cyc_done ? n : -1;
  endtask

  task automatic run(input logic io, input logic [1:0] k, input logic [19:0] a, output int waits);
    launch(io, k, a);
    measure(waits);
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_up();
  end

  initial begin
    int w;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check(cyc_done == 1'b0, "R1 done low", cyc_done, 0);
    run(1'b0, 2'd0, 20'h00000, w); check(w == 3, "R1 mem low default", w, 3);
    run(1'b0, 2'd0, 20'hF0000, w); check(w == 3, "R1 mem top default", w, 3);
    run(1'b1, 2'd0, 20'h00000, w); check(w == 3, "R1 io default", w, 3);
    run(1'b0, 2'd1, 20'h00000, w); check(w == 3, "R1 dma default", w, 3);
    run(1'b0, 2'd2, 20'h00000, w); check(w == 3, "R1 refresh default", w, 3);

    // R2 register programming
    wr(4'd1, 8'hE4); wr(4'd2, 8'hD2); wr(4'd3, 8'h09);
    wr(4'd4, 8'h10); wr(4'd5, 8'h40); wr(4'd6, 8'h80); wr(4'd7, 8'hF0);
    wr(4'd8, 8'h20); wr(4'd9, 8'hA0);

    // R7 vector walk
    foreach (VEC[i]) begin
      wr(4'd0, VEC[i][32:25]);
      run(VEC[i][24], VEC[i][23:22], VEC[i][21:2], w);
      check(w == int'(VEC[i][1:0]), $sformatf("R7 vector %0d", i), w, int'(VEC[i][1:0]));
    end

    wr(4'd0, 8'h03);
    // R8 READY held low past the count
    rdy_sync = 1'b0;
    launch(1'b0, 2'd0, 20'h40000);
    begin
      bit any = 0;
      for (int k = 0; k < 6; k++) begin
        if (cyc_done) any = 1;
        @(posedge clk); #1;
      end
      check(!any, "R8 no done while READY low", any, 0);
    end
    @(negedge clk); rdy_sync = 1'b1; #1;
    check(cyc_done == 1'b1, "R8 done when READY returns", cyc_done, 1);
    @(posedge clk); #1;
    check(cyc_done == 1'b0, "R9 done one period", cyc_done, 0);

    // R8 short READY hold-off: programmed count dominates
    rdy_sync = 1'b0;
    launch(1'b0, 2'd0, 20'h80000);
    @(negedge clk); rdy_sync = 1'b1;
    @(posedge clk); #1;
    measure(w);
    check(w == 2, "R8 max keeps programmed 3", w + 1, 3);

    // R9 done single period after zero-wait cycle
    run(1'b0, 2'd0, 20'h00000, w);
    check(w == 0, "R7 zero wait", w, 0);
    @(posedge clk); #1;
    check(cyc_done == 1'b0, "R9 done clears", cyc_done, 0);

    // R9 restart during an active cycle
    launch(1'b0, 2'd0, 20'h80000);
    check(cyc_done == 1'b0, "R9 first cycle busy", cyc_done, 0);
    launch(1'b0, 2'd0, 20'h00000);
    check(cyc_done == 1'b1, "R9 restart reloads", cyc_done, 1);
    @(posedge clk); #1;
    check(cyc_done == 1'b0, "R9 restarted cycle closed", cyc_done, 0);

    finish_up();
  end
endmodule